// File: doc/BRIEF.md
# Dual-Channel Tachometer Capture Timer

The block measures the interval between pulses on two fan tachometer lines. Each channel has a 16-bit down-counter. The counter steps on a shared tick taken from the bus clock through a programmable divider. A selected edge on the channel's input copies the running count into that channel's capture register and reloads the counter to all ones. Software can therefore read "all ones minus captured value" as the pulse period in ticks.

Each channel also has a compare register. When equal-compare is enabled and the counter steps onto the compare value, a timeout flag is raised. This reports a fan that has stopped or is too slow. The capture and timeout events set sticky pending flags. A single interrupt line is asserted whenever an enabled flag is pending. All control and status sits behind a small halfword register port with per-byte write strobes.

Register map (halfword index on `reg_addr`):
- 0 and 1: counter A and counter B. A read returns the live count; a write loads the counter.
- 2 and 3: capture A and capture B (read only).
- 4 and 5: compare A and compare B.
- 6: prescaler.
- 7: clock select. Bit 0 runs counter A; bit 3 runs counter B.
- 8: compare config. Bit 2 enables equal-compare on A; bit 6 enables it on B.
- 9: pending flags (read only).
- 10: interrupt enable.
- 11: write-one-to-clear.
- 12: edge select. Bit 0 is for channel A and bit 1 is for channel B. A value of 0 selects the falling edge; a value of 1 selects the rising edge.

Top module: `tach_capture_timer`

## Requirements
- R1: After reset, both counters read 0xFFFF. The pending, interrupt-enable and clock-select registers read 0, and `irq` is low.
- R2: With prescaler value P, a running counter decrements by one every P+1 clock cycles. A write to the prescaler restarts the divider.
- R3: A counter whose clock-select bit is clear (bit 0 for A, bit 3 for B) holds its value.
- R4: With its counter running, a falling edge on a tach input is registered on the third rising clock edge after the input changes. On that edge, the count present then is copied into the capture register and the counter reloads to 0xFFFF. The capture pending flag is set: bit 0 for A, bit 1 for B.
- R5: Setting the edge-select bit makes the channel capture on rising edges instead. A falling edge then causes no capture.
- R6: With equal-compare enabled (bit 2 for A, bit 6 for B), the counter stepping onto its compare value sets the timeout flag: bit 4 for A, bit 5 for B. With equal-compare disabled, no timeout flag is set.
- R7: Writing 1 to a bit of the clear register clears that pending bit. Writing 0 has no effect. Writing 0x3F clears all flags and also reloads both counters to 0xFFFF.
- R8: `irq` is high exactly when some pending bit is set and its interrupt-enable bit, at the same position, is also set.
- R9: When a capture and a timeout fall on the same cycle, both flags are set and the counter reloads to 0xFFFF.
- R10: `reg_be[0]` gates the low byte of a write and `reg_be[1]` gates the high byte. An unstrobed byte keeps its old value.
- R11: A write to a counter register loads the counter with the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Halfword register index |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 2 | Byte enables for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| tach_a | input | 1 | Tach line for channel A, asynchronous |
| tach_b | input | 1 | Tach line for channel B, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
A wrong internal state shows at the ports quickly.
- A divider fault shifts counter readback within P+1 cycles.
- A synchroniser with the wrong depth moves the captured value by one tick on the deterministic prescaler-zero tests.
- A missed reload leaves a non-0xFFFF count on the cycle after capture.

Pending corruption shows on `irq` combinationally, in the same cycle the flag register changes. The coincident capture-and-timeout case is aimed at exactly one clock edge, so priority errors show up as a wrong count or a missing flag.

// File: rtl/tach_pkg.sv
`timescale 1ns/1ps
// Shared constants for the tachometer capture timer: register indices,
// flag positions and control-bit positions. Assumes two channels.
package tach_pkg;
    localparam int NCH       = 2;
    localparam int REG_AW    = 4;
    localparam int FLAG_W    = 6;
    localparam logic [FLAG_W-1:0] CLR_ALL = 6'h3F;

    // Register indices (halfword addressing)
    localparam int ADDR_CNT0   = 0;   // + channel
    localparam int ADDR_CAP0   = 2;   // + channel
    localparam int ADDR_CMP0   = 4;   // + channel
    localparam int ADDR_PSC    = 6;
    localparam int ADDR_CLKSEL = 7;
    localparam int ADDR_CMPCFG = 8;
    localparam int ADDR_PEND   = 9;
    localparam int ADDR_IEN    = 10;
    localparam int ADDR_CLR    = 11;
    localparam int ADDR_EDGE   = 12;

    // Bit position of the clock-select bit for a channel
    function automatic int clksel_bit(input int ch);
        return 3 * ch;
    endfunction

    // Bit position of the equal-compare enable for a channel
    function automatic int eqen_bit(input int ch);
        return 2 + 4 * ch;
    endfunction

    // Pending/enable/clear position of a channel's capture flag
    function automatic int cap_flag(input int ch);
        return ch;
    endfunction

    // Pending/enable/clear position of a channel's timeout flag
    function automatic int to_flag(input int ch);
        return 4 + ch;
    endfunction
endpackage

// File: rtl/tach_prescaler.sv
`timescale 1ns/1ps
// Divides the bus clock into a one-cycle tick every (div + 1) cycles.
// Assumes restart is pulsed whenever div is rewritten.
module tach_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] div,
    input  logic             restart,
    output logic             tick
);
    logic [PSC_W-1:0] div_cnt;

    assign tick = (div_cnt == div);

    // Free-running divider counter, wraps after reaching div
    always_ff @(posedge clk) begin
        if (!rst_n)                 div_cnt <= '0;
        else if (restart || tick)   div_cnt <= '0;
        else                        div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/tach_channel.sv
`timescale 1ns/1ps
// One tach channel: input synchroniser, edge select, down-counter with
// capture-and-reload, and equal-compare timeout detection.
// Assumes tach_in is asynchronous; events are single-cycle pulses.
module tach_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_en,
    input  logic             rise_sel,
    input  logic             tach_in,
    input  logic             eq_en,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             reload_all,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap,
    output logic             cap_evt,
    output logic             to_evt
);
    localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}};

    logic [2:0]       sync_q;
    logic             fall_hit, rise_hit;
    logic [CNT_W-1:0] cnt_dec;

    assign fall_hit = sync_q[2] & ~sync_q[1];
    assign rise_hit = ~sync_q[2] & sync_q[1];
    assign cap_evt  = run_en & (rise_sel ? rise_hit : fall_hit);
    assign cnt_dec  = cnt - CNT_W'(1);
    assign to_evt   = run_en & tick & eq_en & (cnt_dec == cmp_val);

    // Two-flop synchroniser plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tach_in};
    end

    // Counter: clear-all, then capture reload, then software load, then tick
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= RELOAD;
        else if (reload_all)      cnt <= RELOAD;
        else if (cap_evt)         cnt <= RELOAD;
        else if (load)            cnt <= load_val;
        else if (run_en && tick)  cnt <= cnt_dec;
    end

    // Capture register latches the live count on the selected edge
    always_ff @(posedge clk) begin
        if (!rst_n)       cap <= '0;
        else if (cap_evt) cap <= cnt;
    end
endmodule

// File: rtl/tach_capture_timer.sv
`timescale 1ns/1ps
// Dual-channel tachometer capture timer top: register file, shared
// prescaler, two channels, sticky pending flags and the interrupt.
// Assumes CNT_W is a multiple of 8 and PSC_W <= 8.
module tach_capture_timer
    import tach_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [CNT_W/8-1:0]  reg_be,
    input  logic [CNT_W-1:0]    reg_wdata,
    output logic [CNT_W-1:0]    reg_rdata,
    input  logic                tach_a,
    input  logic                tach_b,
    output logic                irq
);
    localparam int BE_W  = CNT_W / 8;
    localparam int NREGS = 2 ** REG_AW;

    logic [NREGS-1:0]            wr_sel;
    logic [PSC_W-1:0]            psc_q;
    logic [NCH-1:0]              en_q, eqen_q, rise_q, tach_v;
    logic [FLAG_W-1:0]           pend_q, ien_q, set_vec, clr_mask;
    logic [CNT_W-1:0]            cmp_q [NCH];
    logic [NCH-1:0][CNT_W-1:0]   cnt_v, cap_v;
    logic [NCH-1:0]              load_v, cap_evt_v, to_evt_v;
    logic                        tick, clr_hit, clear_all;

    // Replace only the strobed bytes of a register
    function automatic logic [CNT_W-1:0] merge_bytes(
        input logic [CNT_W-1:0] old_v,
        input logic [CNT_W-1:0] new_v,
        input logic [BE_W-1:0]  be
    );
        merge_bytes = old_v;
        for (int b = 0; b < BE_W; b++)
            if (be[b]) merge_bytes[8*b +: 8] = new_v[8*b +: 8];
    endfunction

    assign wr_sel    = reg_wr ? (NREGS'(1) << reg_addr) : '0;
    assign tach_v    = {tach_b, tach_a};
    assign clr_hit   = wr_sel[ADDR_CLR] && reg_be[0];
    assign clr_mask  = clr_hit ? reg_wdata[FLAG_W-1:0] : '0;
    assign clear_all = clr_hit && (reg_wdata[FLAG_W-1:0] == CLR_ALL);
    assign irq       = |(pend_q & ien_q);

    tach_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (psc_q),
        .restart (wr_sel[ADDR_PSC] && reg_be[0]),
        .tick    (tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign load_v[g] = wr_sel[ADDR_CNT0 + g] && (|reg_be);

        tach_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .run_en     (en_q[g]),
            .rise_sel   (rise_q[g]),
            .tach_in    (tach_v[g]),
            .eq_en      (eqen_q[g]),
            .cmp_val    (cmp_q[g]),
            .load       (load_v[g]),
            .load_val   (merge_bytes(cnt_v[g], reg_wdata, reg_be)),
            .reload_all (clear_all),
            .cnt        (cnt_v[g]),
            .cap        (cap_v[g]),
            .cap_evt    (cap_evt_v[g]),
            .to_evt     (to_evt_v[g])
        );
    end

    // Gather per-channel events into flag positions
    always_comb begin
        set_vec = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            set_vec[cap_flag(ch)] = cap_evt_v[ch];
            set_vec[to_flag(ch)]  = to_evt_v[ch];
        end
    end

    // Control registers and sticky pending flags (set beats clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q  <= '0;
            en_q   <= '0;
            eqen_q <= '0;
            rise_q <= '0;
            ien_q  <= '0;
            pend_q <= '0;
            for (int ch = 0; ch < NCH; ch++) cmp_q[ch] <= '0;
        end else begin
            if (wr_sel[ADDR_PSC] && reg_be[0])    psc_q <= reg_wdata[PSC_W-1:0];
            if (wr_sel[ADDR_IEN] && reg_be[0])    ien_q <= reg_wdata[FLAG_W-1:0];
            for (int ch = 0; ch < NCH; ch++) begin
                if (wr_sel[ADDR_CLKSEL] && reg_be[0]) en_q[ch]   <= reg_wdata[clksel_bit(ch)];
                if (wr_sel[ADDR_CMPCFG] && reg_be[0]) eqen_q[ch] <= reg_wdata[eqen_bit(ch)];
                if (wr_sel[ADDR_EDGE] && reg_be[0])   rise_q[ch] <= reg_wdata[ch];
                if (wr_sel[ADDR_CMP0 + ch])
                    cmp_q[ch] <= merge_bytes(cmp_q[ch], reg_wdata, reg_be);
            end
            pend_q <= (pend_q & ~clr_mask) | set_vec;
        end
    end

    // Combinational read mux
    always_comb begin
        reg_rdata = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (reg_addr == REG_AW'(ADDR_CNT0 + ch)) reg_rdata = cnt_v[ch];
            if (reg_addr == REG_AW'(ADDR_CAP0 + ch)) reg_rdata = cap_v[ch];
            if (reg_addr == REG_AW'(ADDR_CMP0 + ch)) reg_rdata = cmp_q[ch];
            if (reg_addr == REG_AW'(ADDR_CLKSEL))    reg_rdata[clksel_bit(ch)] = en_q[ch];
            if (reg_addr == REG_AW'(ADDR_CMPCFG))    reg_rdata[eqen_bit(ch)]   = eqen_q[ch];
            if (reg_addr == REG_AW'(ADDR_EDGE))      reg_rdata[ch]             = rise_q[ch];
        end
        if (reg_addr == REG_AW'(ADDR_PSC))  reg_rdata[PSC_W-1:0]  = psc_q;
        if (reg_addr == REG_AW'(ADDR_PEND)) reg_rdata[FLAG_W-1:0] = pend_q;
        if (reg_addr == REG_AW'(ADDR_IEN))  reg_rdata[FLAG_W-1:0] = ien_q;
    end
endmodule

// File: rtl/tach_capture_timer_chk.sv
`timescale 1ns/1ps
// Property checker for the tachometer capture timer, bound to the top.
// Observes flag, counter and event signals between the submodules.
module tach_capture_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     irq,
    input logic [5:0]               pend,
    input logic                     ien_to_b,
    input logic [1:0][CNT_W-1:0]    cnt,
    input logic [1:0]               en,
    input logic [1:0]               load,
    input logic                     clear_all,
    input logic                     cap_evt_a,
    input logic                     to_evt_a,
    input logic                     clr_cap_a
);
    localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pend == 6'd0 && cnt[0] == ONES && cnt[1] == ONES));

    // R3
    hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en[0] && !load[0] && !clear_all) |=> (cnt[0] == $past(cnt[0])));

    // R3
    hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en[1] && !load[1] && !clear_all) |=> (cnt[1] == $past(cnt[1])));

    // R4
    capture_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_a |=> (cnt[0] == ONES && pend[0]));

    // R6
    timeout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_evt_a |=> pend[4]);

    // R7
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cap_a && !cap_evt_a) |=> !pend[0]);

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[5] && ien_to_b) |-> irq);

    // R9
    both_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt_a && to_evt_a) |=> (pend[0] && pend[4] && cnt[0] == ONES));
endmodule

bind tach_capture_timer tach_capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .pend      (pend_q),
    .ien_to_b  (ien_q[5]),
    .cnt       (cnt_v),
    .en        (en_q),
    .load      (load_v),
    .clear_all (clear_all),
    .cap_evt_a (cap_evt_v[0]),
    .to_evt_a  (to_evt_v[0]),
    .clr_cap_a (clr_mask[0])
);

// File: tb/tach_capture_timer_tb.sv
`timescale 1ns/1ps
// Directed bench for the tachometer capture timer: one task per scenario.
module tach_capture_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_be = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tach_a = 1'b1;
    logic        tach_b = 1'b1;
    logic        irq;
    int          n_tests = 0;
    int          n_fail  = 0;

    always #4 clk = ~clk;   // 125 MHz

    tach_capture_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tach_a(tach_a), .tach_b(tach_b), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    // Write lands on the next rising edge; returns at the following falling edge
    task automatic wr(input int a, input logic [15:0] d, input logic [1:0] be = 2'b11);
        @(negedge clk);
        reg_addr = 4'(a); reg_wdata = d; reg_be = be; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        reg_addr = 4'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(0, v);  chk("R1 counter A", v, 16'hFFFF);
        rd(1, v);  chk("R1 counter B", v, 16'hFFFF);
        rd(9, v);  chk("R1 pending", v, 16'h0000);
        rd(10, v); chk("R1 int enable", v, 16'h0000);
        rd(7, v);  chk("R1 clock select", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_byte_lanes;
        logic [15:0] v;
        wr(1, 16'h1234);        rd(1, v); chk("R11 counter B load", v, 16'h1234);
        wr(1, 16'h00AB, 2'b01); rd(1, v); chk("R10 low byte only", v, 16'h12AB);
        wr(1, 16'hCD00, 2'b10); rd(1, v); chk("R10 high byte only", v, 16'hCDAB);
    endtask

    task automatic t_prescale_hold;
        logic [15:0] v, prev;
        wr(6, 16'd3);
        wr(0, 16'h0100);
        wr(7, 16'h0001);
        rd(0, prev); v = prev;
        for (int i = 0; i < 20 && v == prev; i++) begin
            @(negedge clk); rd(0, v);
        end
        repeat (40) @(negedge clk);
        rd(0, prev); chk("R2 ten ticks in 40 cycles", prev, v - 16'd10);
        rd(1, v);    chk("R3 counter B held while disabled", v, 16'hCDAB);
        wr(7, 16'h0000);
        rd(0, v);
        repeat (20) @(negedge clk);
        rd(0, prev); chk("R3 counter A held after stop", prev, v);
    endtask

    task automatic t_capture_a_slow;
        logic [15:0] v, prev;
        wr(0, 16'h4000);
        wr(6, 16'd255);
        wr(7, 16'h0001);
        rd(0, prev); v = prev;
        for (int i = 0; i < 600 && v == prev; i++) begin
            @(negedge clk); rd(0, v);
        end
        tach_a = 1'b0;
        repeat (4) @(negedge clk);
        rd(2, prev); chk("R4 capture A value", prev, v);
        rd(0, prev); chk("R4 counter A reloaded", prev, 16'hFFFF);
        rd(9, prev); chk("R4 capture A flag only", prev & 16'h0003, 16'h0001);
        tach_a = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_capture_b;
        logic [15:0] v;
        wr(6, 16'd0);
        wr(7, 16'h0008);
        wr(1, 16'h3000);
        tach_b = 1'b0;
        repeat (3) @(negedge clk);
        rd(3, v); chk("R4 capture B value", v, 16'h2FFE);
        rd(1, v); chk("R4 counter B reloaded", v, 16'hFFFF);
        rd(9, v); chk("R4 capture B flag bit1", v & 16'h0002, 16'h0002);
        tach_b = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_polarity;
        logic [15:0] v;
        wr(11, 16'h003F);
        wr(7, 16'h0001);
        wr(12, 16'h0001);
        tach_a = 1'b0;
        repeat (6) @(negedge clk);
        rd(9, v); chk("R5 falling edge ignored in rising mode", v, 16'h0000);
        wr(0, 16'h5000);
        tach_a = 1'b1;
        repeat (3) @(negedge clk);
        rd(2, v); chk("R5 rising capture value", v, 16'h4FFE);
        rd(9, v); chk("R5 rising capture flag", v & 16'h0001, 16'h0001);
        wr(12, 16'h0000);
        wr(11, 16'h003F);
    endtask

    task automatic t_timeout;
        logic [15:0] v;
        wr(11, 16'h003F);
        wr(6, 16'd0);
        wr(8, 16'h0044);
        wr(4, 16'h1000);
        wr(5, 16'h2000);
        wr(0, 16'h1010);
        wr(1, 16'h2010);
        wr(7, 16'h0009);
        repeat (40) @(negedge clk);
        rd(9, v); chk("R6 both timeout flags", v, 16'h0030);
        chk("R8 irq low without enable", {15'd0, irq}, 16'h0000);
        wr(10, 16'h0020);
        chk("R8 irq high with enable", {15'd0, irq}, 16'h0001);
        wr(11, 16'h0020);
        rd(9, v); chk("R7 clear timeout B only", v, 16'h0010);
        chk("R8 irq drops after clear", {15'd0, irq}, 16'h0000);
        wr(11, 16'h0010);
        wr(8, 16'h0000);
        wr(0, 16'h1010);
        repeat (40) @(negedge clk);
        rd(9, v); chk("R6 no timeout when compare disabled", v, 16'h0000);
        wr(10, 16'h0000);
    endtask

    task automatic t_same_cycle;
        logic [15:0] v;
        wr(7, 16'h0001);
        wr(8, 16'h0004);
        wr(4, 16'h1FFD);
        wr(11, 16'h003F);
        wr(0, 16'h2000);
        tach_a = 1'b0;
        repeat (3) @(negedge clk);
        rd(9, v); chk("R9 capture and timeout flags", v, 16'h0011);
        rd(2, v); chk("R9 capture value", v, 16'h1FFE);
        rd(0, v); chk("R9 counter reloaded", v, 16'hFFFF);
        tach_a = 1'b1;
    endtask

    task automatic t_clear;
        logic [15:0] v;
        wr(11, 16'h0000);
        rd(9, v); chk("R7 zero write has no effect", v, 16'h0011);
        wr(7, 16'h0000);
        wr(0, 16'h1234);
        wr(11, 16'h003F);
        rd(9, v); chk("R7 full clear flags", v, 16'h0000);
        rd(0, v); chk("R7 full clear reloads A", v, 16'hFFFF);
        rd(1, v); chk("R7 full clear reloads B", v, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_lanes();
        t_prescale_hold();
        t_capture_a_slow();
        t_capture_b();
        t_polarity();
        t_timeout();
        t_same_cycle();
        t_clear();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule